// File: doc/BRIEF.md
# Single-Data-Rate SDRAM Controller with Pipelined Host Port

This block sits between on-chip logic and one external single-data-rate SDRAM device. The host sees a plain memory port: one flat word-addressed space as large as the device, with a stall signal (`host_wait`) and a read-return strobe (`host_rvalid`). Everything about the SDRAM command protocol stays inside the block: power-up initialisation, opening and closing rows, column reads and writes, and periodic auto-refresh. There are no registers for software; every timing figure is an elaboration-time parameter.

The host address is split, from the top bit down, into bank, row and column. Each bank keeps one row open. A request that hits the open row of its bank goes out as a READ or WRITE command in the very cycle it is accepted. Reads return on `host_rvalid` exactly `CAS_LAT` cycles later, so a run of reads to one row streams one word per cycle. A refresh can cut into such a run at any moment.

The controller is one state machine. Its states are POWERUP, INIT_PALL, INIT_REF1, INIT_REF2, INIT_MODE, IDLE, PRECHARGE, ACTIVATE, REF_PALL and REFRESH. A shared wait counter holds any state until the delay of its previous command has run out. The transitions are:
- the reset path: POWERUP→INIT_PALL→INIT_REF1→INIT_REF2→INIT_MODE→IDLE.
- the row-miss path: IDLE→PRECHARGE→ACTIVATE→IDLE when another row is open in the bank, and IDLE→ACTIVATE→IDLE when the bank is closed.
- the refresh path: IDLE→REF_PALL→REFRESH→IDLE.

Top module: `sdram_ctrl`

## Requirements
- R1: A read returns the most recent data written to the same host address. The host address is {bank, row, column}, with the bank in the top bits and the column in the low bits.
- R2: After reset, the controller keeps every command NOP for `T_POWERUP` cycles, with `mem_cke` high. It then issues precharge-all (address bit 10 = 1), two AUTO REFRESH commands and LOAD MODE. The LOAD MODE address carries `CAS_LAT` in bits 6:4 and zeros in bits 3:0 (sequential, burst length 1). `host_wait` stays high until all of these have been issued.
- R3: Commands on {cs_n, ras_n, cas_n, we_n} are NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, AUTO REFRESH=0001, LOAD MODE=0000.
- R4: A READ or WRITE command goes out only in a cycle in which `host_wait` is low for the pending request. While `host_wait` is high, nothing is accepted.
- R5: `host_rvalid` is high exactly `CAS_LAT` cycles after each READ command. In that cycle `host_rdata` is the word on `mem_dq`.
- R6: Requests to an open row are accepted on consecutive cycles, so sequential reads return one word per cycle.
- R7: On a row miss, the controller precharges the bank if it is open, then issues ACTIVE no sooner than `T_RP` cycles later, and issues READ/WRITE no sooner than `T_RCD` cycles after ACTIVE. ACTIVE goes only to a closed bank, and READ/WRITE only to an open one.
- R8: Refresh comes due every `REF_INTERVAL` cycles. When it does, the controller precharges all banks and issues AUTO REFRESH with every bank closed. It then issues no command for `T_RC` cycles.
- R9: On WRITE, `mem_dq` carries the host data and `mem_dqm` is the inverse of `host_be`. Bytes whose enable is low keep their old contents.
- R10: No WRITE is issued while read data is still due on `mem_dq`, and no WRITE follows a READ in the next cycle.
- R11: During reset `host_wait` is high, `host_rvalid` is low and the command is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and SDRAM clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | BANK_W+ROW_W+COL_W | Word address {bank,row,column} |
| host_rd | input | 1 | Read request |
| host_wr | input | 1 | Write request |
| host_wdata | input | DATA_W | Write data |
| host_be | input | DATA_W/8 | Byte enables for writes |
| host_rdata | output | DATA_W | Read data, valid with host_rvalid |
| host_wait | output | 1 | Stall: the request is not accepted this cycle |
| host_rvalid | output | 1 | Read data strobe |
| mem_cke | output | 1 | SDRAM clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BANK_W | Bank address |
| mem_a | output | ROW_W | Multiplexed row/column address |
| mem_dqm | output | DATA_W/8 | Data mask |
| mem_dq | inout | DATA_W | Bidirectional data bus |

## Verification
The embedded assertions check the behaviour that holds on every cycle:
- the read-return latency of exactly `CAS_LAT` after each READ.
- no WRITE directly after a READ or while read data is due on the bus.
- no acceptance before initialisation ends.
- every bank closed at AUTO REFRESH.
- ACTIVE only to a closed bank.
- a pending refresh staying pending until it is served.

The bench scenarios show what depends on stimulus and on the memory's contents:
- data integrity under masked writes and row misses.
- the order and mode value of the start-up commands.
- timing gaps as seen by a device model.
- unbroken one-word-per-cycle read streams.
- the spacing of refreshes over a long random run.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

    // Command code on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_INIT_PALL,
        ST_INIT_REF1,
        ST_INIT_REF2,
        ST_INIT_MODE,
        ST_IDLE,
        ST_PRECHARGE,
        ST_ACTIVATE,
        ST_REF_PALL,
        ST_REFRESH
    } ctrl_state_e;

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int INTERVAL = 390
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic due
);
    localparam int CNT_W = $clog2(INTERVAL + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= CNT_W'(INTERVAL - 1);
            due <= 1'b0;
        end else begin
            cnt <= (cnt == '0) ? CNT_W'(INTERVAL - 1) : cnt - 1'b1;
            due <= (cnt == '0) | (due & ~ack);
        end
    end

    // A due refresh stays pending until served
    assert_due_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (due && !ack && en) |=> due);

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic issue,
    output logic valid,
    output logic busy
);
    logic [LAT-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[LAT-2:0], issue};
    end

    assign valid = sr[LAT-1];
    assign busy  = |sr;

endmodule

// File: rtl/sdr_bank_table.sv
module sdr_bank_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    input  logic              act_en,
    input  logic              close_en,
    input  logic              close_all,
    output logic              bank_open,
    output logic              row_hit,
    output logic              any_open
);
    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0] open_v;
    logic [ROW_W-1:0] row_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst || close_all) begin
                open_v[b] <= 1'b0;
            end else if (lk_bank == BANK_W'(b)) begin
                if (act_en) begin
                    open_v[b] <= 1'b1;
                    row_q[b]  <= lk_row;
                end else if (close_en) begin
                    open_v[b] <= 1'b0;
                end
            end
        end
    end

    assign bank_open = open_v[lk_bank];
    assign row_hit   = bank_open && (row_q[lk_bank] == lk_row);
    assign any_open  = |open_v;

endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
    import sdram_ctrl_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 12,
    parameter int COL_W        = 8,
    parameter int CAS_LAT      = 2,
    parameter int T_POWERUP    = 100,
    parameter int T_RP         = 2,
    parameter int T_RCD        = 2,
    parameter int T_RC         = 7,
    parameter int T_MRD        = 2,
    parameter int T_WR         = 2,
    parameter int REF_INTERVAL = 390
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [BANK_W+ROW_W+COL_W-1:0] host_addr,
    input  logic                          host_rd,
    input  logic                          host_wr,
    input  logic [DATA_W-1:0]             host_wdata,
    input  logic [DATA_W/8-1:0]           host_be,
    output logic [DATA_W-1:0]             host_rdata,
    output logic                          host_wait,
    output logic                          host_rvalid,
    output logic                          mem_cke,
    output logic                          mem_cs_n,
    output logic                          mem_ras_n,
    output logic                          mem_cas_n,
    output logic                          mem_we_n,
    output logic [BANK_W-1:0]             mem_ba,
    output logic [ROW_W-1:0]              mem_a,
    output logic [DATA_W/8-1:0]           mem_dqm,
    inout  wire  [DATA_W-1:0]             mem_dq
);
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int BE_W   = DATA_W / 8;
    localparam int WAIT_W = $clog2(T_POWERUP + T_RC + 2);
    localparam int WR_W   = $clog2(T_WR + 1);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);
    localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1 << 10);

    ctrl_state_e       state, nxt_state;
    logic [WAIT_W-1:0] wait_cnt, nxt_wait;
    logic [WR_W-1:0]   wr_cnt;
    sdr_cmd_e          cmd;
    logic              dq_oe, rd_issue, wr_issue;
    logic              act_en, close_en, close_all, ref_ack;
    logic              bank_open, row_hit, any_open, rd_busy, ref_due, running;

    logic [BANK_W-1:0] h_bank;
    logic [ROW_W-1:0]  h_row;
    logic [COL_W-1:0]  h_col;

    assign h_bank  = host_addr[ADDR_W-1 -: BANK_W];
    assign h_row   = host_addr[COL_W +: ROW_W];
    assign h_col   = host_addr[COL_W-1:0];
    assign running = (state != ST_POWERUP) && (state != ST_INIT_PALL) &&
                     (state != ST_INIT_REF1) && (state != ST_INIT_REF2) &&
                     (state != ST_INIT_MODE);

    sdr_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
        .clk(clk), .rst(rst), .lk_bank(h_bank), .lk_row(h_row),
        .act_en(act_en), .close_en(close_en), .close_all(close_all),
        .bank_open(bank_open), .row_hit(row_hit), .any_open(any_open)
    );

    sdr_rd_pipe #(.LAT(CAS_LAT)) u_rdpipe (
        .clk(clk), .rst(rst), .issue(rd_issue),
        .valid(host_rvalid), .busy(rd_busy)
    );

    sdr_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_reftmr (
        .clk(clk), .rst(rst), .en(running), .ack(ref_ack), .due(ref_due)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_POWERUP;
            wait_cnt <= WAIT_W'(T_POWERUP);
            wr_cnt   <= '0;
            mem_cke  <= 1'b0;
        end else begin
            state    <= nxt_state;
            wait_cnt <= nxt_wait;
            wr_cnt   <= wr_issue ? WR_W'(T_WR) : (wr_cnt != '0 ? wr_cnt - 1'b1 : '0);
            mem_cke  <= 1'b1;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt_state = state;
        nxt_wait  = (wait_cnt != '0) ? wait_cnt - 1'b1 : '0;
        cmd       = CMD_NOP;
        mem_ba    = '0;
        mem_a     = '0;
        mem_dqm   = '0;
        dq_oe     = 1'b0;
        host_wait = 1'b1;
        rd_issue  = 1'b0;
        wr_issue  = 1'b0;
        act_en    = 1'b0;
        close_en  = 1'b0;
        close_all = 1'b0;
        ref_ack   = 1'b0;
        if (!rst && wait_cnt == '0) begin
            unique case (state)
                ST_POWERUP: nxt_state = ST_INIT_PALL;
                ST_INIT_PALL, ST_REF_PALL: begin
                    cmd       = CMD_PRE;
                    mem_a     = ALL_BANKS;
                    close_all = 1'b1;
                    nxt_wait  = WAIT_W'(T_RP - 1);
                    nxt_state = (state == ST_INIT_PALL) ? ST_INIT_REF1 : ST_REFRESH;
                end
                ST_INIT_REF1, ST_INIT_REF2, ST_REFRESH: begin
                    cmd       = CMD_REF;
                    ref_ack   = (state == ST_REFRESH);
                    nxt_wait  = WAIT_W'(T_RC - 1);
                    nxt_state = (state == ST_INIT_REF1) ? ST_INIT_REF2 :
                                (state == ST_INIT_REF2) ? ST_INIT_MODE : ST_IDLE;
                end
                ST_INIT_MODE: begin
                    cmd       = CMD_LMR;
                    mem_a     = MODE_WORD;
                    nxt_wait  = WAIT_W'(T_MRD - 1);
                    nxt_state = ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_due) begin
                        if (!rd_busy && wr_cnt == '0) nxt_state = ST_REF_PALL;
                    end else if (host_rd || host_wr) begin
                        if (row_hit) begin
                            mem_ba = h_bank;
                            mem_a  = ROW_W'(h_col);
                            if (host_rd) begin
                                cmd       = CMD_RD;
                                rd_issue  = 1'b1;
                                host_wait = 1'b0;
                            end else if (!rd_busy) begin
                                cmd       = CMD_WR;
                                wr_issue  = 1'b1;
                                dq_oe     = 1'b1;
                                mem_dqm   = ~host_be;
                                host_wait = 1'b0;
                            end
                        end else if (bank_open) begin
                            if (wr_cnt == '0) nxt_state = ST_PRECHARGE;
                        end else begin
                            nxt_state = ST_ACTIVATE;
                        end
                    end
                end
                ST_PRECHARGE: begin
                    cmd       = CMD_PRE;
                    mem_ba    = h_bank;
                    close_en  = 1'b1;
                    nxt_wait  = WAIT_W'(T_RP - 1);
                    nxt_state = ST_ACTIVATE;
                end
                ST_ACTIVATE: begin
                    cmd       = CMD_ACT;
                    mem_ba    = h_bank;
                    mem_a     = h_row;
                    act_en    = 1'b1;
                    nxt_wait  = WAIT_W'(T_RCD - 1);
                    nxt_state = ST_IDLE;
                end
                default: nxt_state = ST_POWERUP;
            endcase
        end
    end

    assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;
    assign mem_dq     = dq_oe ? host_wdata : {DATA_W{1'bz}};
    assign host_rdata = mem_dq;

    // Checker state: set once LOAD MODE has been issued
    logic init_seen;
    always_ff @(posedge clk) begin
        if (rst)                 init_seen <= 1'b0;
        else if (cmd == CMD_LMR) init_seen <= 1'b1;
    end

    assert_rdv_latency_R5: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(cmd == CMD_RD, CAS_LAT));
    assert_no_wr_after_rd_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD) |=> (cmd != CMD_WR));
    assert_no_wr_over_rdata_R10: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> (cmd != CMD_WR));
    assert_no_accept_in_init_R2: assert property (@(posedge clk) disable iff (rst)
        !host_wait |-> init_seen);
    assert_refresh_all_closed_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REF) |-> !any_open);
    assert_act_closed_bank_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT) |-> !bank_open);

endmodule

// File: tb/sdram_ctrl_tb.sv
module sdram_ctrl_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DW = 16, BW = 2, RW = 12, CW = 8, BEW = DW / 8;
    localparam int CL = 3, TPU = 40, TRP = 2, TRCD = 2, TRC = 7, TMRD = 2, TWR = 2;
    localparam int RINT = 150;
    localparam int AW = BW + RW + CW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [AW-1:0]  host_addr = '0;
    logic           host_rd = 1'b0, host_wr = 1'b0;
    logic [DW-1:0]  host_wdata = '0;
    logic [BEW-1:0] host_be = '0;
    logic [DW-1:0]  host_rdata;
    logic           host_wait, host_rvalid;
    logic           mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [BW-1:0]  mem_ba;
    logic [RW-1:0]  mem_a;
    logic [BEW-1:0] mem_dqm;
    wire  [DW-1:0]  mem_dq;

    sdram_ctrl #(.DATA_W(DW), .BANK_W(BW), .ROW_W(RW), .COL_W(CW), .CAS_LAT(CL),
                 .T_POWERUP(TPU), .T_RP(TRP), .T_RCD(TRCD), .T_RC(TRC), .T_MRD(TMRD),
                 .T_WR(TWR), .REF_INTERVAL(RINT)) u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_be(host_be), .host_rdata(host_rdata),
        .host_wait(host_wait), .host_rvalid(host_rvalid), .mem_cke(mem_cke),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_a(mem_a), .mem_dqm(mem_dqm),
        .mem_dq(mem_dq)
    );

    int n_checks = 0, n_fail = 0;
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [BEW-1:0] be);
        logic [DW-1:0] r = old;
        for (int i = 0; i < BEW; i++) if (be[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [AW-1:0] mk_addr(input int b, input int r, input int c);
        return {BW'(b), RW'(r), CW'(c)};
    endfunction

    // ---------------- SDRAM device model (R3 encodings) ----------------
    int cyc = 0;
    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    logic [DW-1:0] dev_mem [int];
    bit  [3:0]     b_open = '0;
    int            b_row [4];
    int            last_pre [4];
    int            last_act [4];
    int            last_ref = -1000, n_ref = 0, max_gap = 0, first_cmd = -1, n_init = 0;
    logic [3:0]    init_cmd [4];
    logic [RW-1:0] mode_val = '0;
    logic [CL-1:0] mv = '0;
    logic [DW-1:0] md [CL];
    int            rd_cyc_q [$];
    logic [3:0]    prev_cmd = 4'b0111;
    assign mem_dq = mv[CL-1] ? md[CL-1] : {DW{1'bz}};

    always @(posedge clk) begin
        logic [3:0] c;
        int key;
        c   = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
        key = {mem_ba, b_row[mem_ba][RW-1:0], mem_a[CW-1:0]};
        mv <= {mv[CL-2:0], 1'b0};
        for (int i = 1; i < CL; i++) md[i] <= md[i-1];
        prev_cmd <= rst ? 4'b0111 : c;
        if (rst) begin
            b_open <= '0;
            check(c == 4'b0111 && host_wait && !host_rvalid, "R11", "reset outputs",
                  {c, host_wait, host_rvalid}, {4'b0111, 2'b10});
        end else if (c != 4'b0111) begin
            if (first_cmd < 0) begin
                first_cmd = cyc;
                check(cyc >= TPU && mem_cke, "R2", "power-up NOP span", cyc, TPU);
            end
            if (n_init < 4) begin
                init_cmd[n_init] = c;
                if (n_init == 0) check(mem_a[10], "R2", "precharge-all bit", mem_a[10], 1);
                if (c == 4'b0000) mode_val = mem_a;
                n_init++;
            end
            if (n_ref > 0) check(cyc - last_ref >= TRC, "R8", "tRC after refresh",
                                 cyc - last_ref, TRC);
            case (c)
                4'b0011: begin
                    check(!b_open[mem_ba], "R7", "ACTIVE to closed bank", b_open[mem_ba], 0);
                    check(cyc - last_pre[mem_ba] >= TRP, "R7", "tRP", cyc - last_pre[mem_ba], TRP);
                    b_open[mem_ba] <= 1'b1;
                    b_row[mem_ba] = int'(mem_a);
                    last_act[mem_ba] = cyc;
                end
                4'b0101, 4'b0100: begin
                    check(b_open[mem_ba], "R7", "column cmd to open bank", b_open[mem_ba], 1);
                    check(cyc - last_act[mem_ba] >= TRCD, "R7", "tRCD",
                          cyc - last_act[mem_ba], TRCD);
                    check(!host_wait, "R4", "column cmd only when accepted", host_wait, 0);
                    if (c == 4'b0101) begin
                        mv[0] <= 1'b1;
                        md[0] <= dev_mem.exists(key) ? dev_mem[key] : '0;
                        rd_cyc_q.push_back(cyc);
                    end else begin
                        check(mv == '0 && prev_cmd != 4'b0101, "R10", "write bus turnaround",
                              mv, 0);
                        check(mem_dq == host_wdata, "R9", "dq carries write data",
                              mem_dq, host_wdata);
                        check(mem_dqm == ~host_be, "R9", "dqm inverse of be", mem_dqm, ~host_be);
                        dev_mem[key] = merge(dev_mem.exists(key) ? dev_mem[key] : '0,
                                             mem_dq, ~mem_dqm);
                    end
                end
                4'b0010: begin
                    if (mem_a[10]) begin
                        b_open <= '0;
                        for (int i = 0; i < 4; i++) last_pre[i] = cyc;
                    end else begin
                        b_open[mem_ba] <= 1'b0;
                        last_pre[mem_ba] = cyc;
                    end
                end
                4'b0001: begin
                    check(b_open == '0, "R8", "all banks closed at refresh", b_open, 0);
                    if (n_ref >= 2 && cyc - last_ref > max_gap) max_gap = cyc - last_ref;
                    last_ref = cyc;
                    n_ref++;
                end
                default: ;
            endcase
        end
    end

    // ---------------- Host-side scoreboard ----------------
    logic [DW-1:0] ref_mem [int];
    logic [DW-1:0] exp_q [$];
    int run = 0, max_run = 0, acc_run = 0, max_acc_run = 0, first_accept = -1;

    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if ((host_rd || host_wr) && !host_wait) begin
                if (first_accept < 0) first_accept = cyc;
                acc_run = host_rd ? acc_run + 1 : 0;
                if (acc_run > max_acc_run) max_acc_run = acc_run;
                if (host_rd)
                    exp_q.push_back(ref_mem.exists(int'(host_addr)) ? ref_mem[int'(host_addr)] : '0);
                else
                    ref_mem[int'(host_addr)] = merge(ref_mem.exists(int'(host_addr)) ?
                                                     ref_mem[int'(host_addr)] : '0,
                                                     host_wdata, host_be);
            end else acc_run = 0;
            if (host_rvalid) begin
                int rc;
                logic [DW-1:0] e;
                run++;
                if (run > max_run) max_run = run;
                rc = (rd_cyc_q.size() > 0) ? rd_cyc_q.pop_front() : -1;
                check(cyc - rc == CL, "R5", "read latency", cyc - rc, CL);
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
                check(host_rdata === e, "R1", "read data", host_rdata, e);
            end else run = 0;
        end
    end

    task automatic host_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [BEW-1:0] be);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_be = be; host_rd = !wr; host_wr = wr;
        forever begin
            #2;
            if (!host_wait) break;
            @(negedge clk);
        end
        @(posedge clk);
    endtask

    task automatic host_idle(input int n);
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R4", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(host_wait && !host_rvalid, "R11", "wait high in reset", host_wait, 1);
        rst = 1'b0;

        // R2: start-up sequence, then the first accepted write
        host_op(1, mk_addr(0, 1, 0), 16'hA5A5, 2'b11);
        check(first_accept > TPU, "R2", "no accept during init", first_accept, TPU);
        check(init_cmd[0] == 4'b0010 && init_cmd[1] == 4'b0001 && init_cmd[2] == 4'b0001 &&
              init_cmd[3] == 4'b0000, "R2", "init order",
              {init_cmd[0], init_cmd[1], init_cmd[2], init_cmd[3]}, 16'h2110);
        check(mode_val[6:4] == CL && mode_val[3:0] == 0, "R2", "mode word", mode_val, CL << 4);

        // R9: masked write keeps the disabled byte
        host_op(1, mk_addr(0, 1, 0), 16'h1234, 2'b01);
        host_op(0, mk_addr(0, 1, 0), '0, '0);
        host_idle(8);

        // R7: row misses in one bank, and across banks
        host_op(1, mk_addr(0, 2, 3), 16'hBEEF, 2'b11);
        host_op(1, mk_addr(3, 7, 3), 16'hCAFE, 2'b11);
        host_op(0, mk_addr(0, 1, 0), '0, '0);
        host_op(0, mk_addr(0, 2, 3), '0, '0);
        host_op(0, mk_addr(3, 7, 3), '0, '0);
        host_idle(8);

        // R6: sequential stream in one row
        for (int i = 0; i < 16; i++) host_op(1, mk_addr(1, 5, i), 16'h1000 + 16'(i), 2'b11);
        for (int i = 0; i < 16; i++) host_op(0, mk_addr(1, 5, i), '0, '0);
        host_idle(10);
        check(max_acc_run >= 8, "R6", "back-to-back read accepts", max_acc_run, 8);
        check(max_run >= 8, "R6", "one word per cycle", max_run, 8);

        // R10: a write right behind a read
        host_op(0, mk_addr(1, 5, 0), '0, '0);
        host_op(1, mk_addr(1, 5, 1), 16'h7777, 2'b10);
        host_op(0, mk_addr(1, 5, 1), '0, '0);
        host_idle(8);

        // Random mix with hits and misses
        for (int i = 0; i < 500; i++) begin
            bit wr = $urandom_range(0, 1) == 1;
            host_op(wr, mk_addr($urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(0, 7)),
                    DW'($urandom), BEW'($urandom_range(1, 3)));
            if ($urandom_range(0, 7) == 0) host_idle($urandom_range(0, 4));
        end
        host_idle(RINT + 40);

        check(exp_q.size() == 0, "R5", "all reads returned", exp_q.size(), 0);
        check(n_ref >= 2 + cyc / (RINT + 40), "R8", "refresh count", n_ref, 2 + cyc / (RINT + 40));
        check(max_gap <= RINT + 30, "R8", "refresh spacing", max_gap, RINT + 30);
        report();
    end

endmodule